// File: doc/BRIEF.md
# SCSI Controller Interrupt and Status Register Front End

This block is the byte-wide register face of a small SCSI bus controller. It keeps the status, interrupt-cause, sequence-step and transfer-count registers, a few plain scratch registers, and a configuration byte. It decodes writes to the command register and produces one level-sensitive interrupt request. The interrupt is also reflected in bit 0 of a 32-bit DMA control word, and that word carries an interrupt-enable bit that can drop the line.

The bus phase logic, the data FIFO and the DMA datapath sit outside the block. They report back only as single-cycle strobes: selection succeeded, selection failed (no target, or a target index of 4 or more), and transfer finished, with the byte count on `xfer_len`. Software acknowledges an interrupt by reading the interrupt-cause register. That read returns the cause and, at the same clock edge, clears the pending state.

Top module: `scsi_irq_regs`

## Requirements
- R1: The register index is `bus_addr[5:2]`, so there are 16 byte registers on a 4-byte stride and the two low address bits are ignored. `bus_rdata` shows the addressed register combinationally: index 4 is status, 5 is interrupt cause, 6 is sequence step, 7 is transfer count, 11 through 15 are scratch, and every other index reads 0.
- R2: A read strobe on index 5 ANDs status with 0x10, keeping only the terminal-count bit. At the next edge it also clears `irq_o` and DMA control bit 0.
- R3: Command 0x01 (flush) sets the interrupt cause to 0x08 and the sequence step to 0. It does not change `irq_o`.
- R4: Command 0x03 (bus reset) sets the interrupt cause to 0x80. It raises `irq_o` and DMA bit 0 only when bit 6 of the configuration byte is clear. The configuration byte is written at index 8 and cannot be read back.
- R5: A `sel_fail` strobe sets status to 0x80, the interrupt cause to 0x20 and the sequence step to 0, and it raises the interrupt. It takes precedence over `sel_ok` in the same cycle.
- R6: A `sel_ok` strobe sets status to 0x91 (interrupt 0x80, terminal count 0x10, data-in 0x01), the interrupt cause to 0x18 and the sequence step to 4, and it raises the interrupt.
- R7: Either the `xfer_done` strobe or command 0x10 (transfer information) copies `xfer_len` into index 7 and raises the interrupt and DMA bit 0.
- R8: A write to index 11 stores only the bits under mask 0x15. Writes to indices 12 to 15 store the whole byte. Writes to indices 0–2, 4–7, 9 and 10 change nothing.
- R9: `dma_rdata` reads 0xA0000000 OR (enable << 4) OR pending bit 0. A DMA write with bit 7 clear stores bit 4 as the enable, and if that bit is 0 it drops `irq_o` while leaving bit 0 set. A DMA write with bit 7 set performs a full reset that also clears the enable.
- R10: Commands are decoded from `bus_wdata[6:0]` on writes to index 3, and unknown codes have no effect. Command 0x02 (chip reset) clears every register, the configuration byte, DMA bit 0 and `irq_o` in one clock, and it keeps the enable.
- R11: When an interrupt-raising event arrives in the same cycle as the index-5 read, the event wins: `irq_o` stays high and the event's register values stand.
- R12: After `rst_n` is asserted, every register reads 0, `dma_rdata` is 0xA0000000 and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 6 | Byte address of the register bus |
| bus_rd | input | 1 | Read strobe (destructive on index 5) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| dma_wr | input | 1 | DMA control word write strobe |
| dma_wdata | input | 32 | DMA control write data |
| dma_rdata | output | 32 | DMA control word read-back |
| ev_sel_ok | input | 1 | Selection succeeded strobe |
| ev_sel_fail | input | 1 | Selection failed strobe |
| ev_xfer_done | input | 1 | Transfer finished strobe |
| xfer_len | input | 8 | Transfer byte count |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench checks that the acknowledging read really is destructive. It also checks that the terminal-count bit survives that read. A design that cleared all of status, or that left the line high, would be caught at once. The bench drives a selection event in the same cycle as the acknowledge read. A design that applied the clear last would lose that interrupt. Bus reset is tried with the quiet bit both set and clear, and a command byte with bit 7 set tests the 7-bit decode. Scratch writes at masked and ignored indices show any missing mask or stray write. The enable-low DMA write must drop the line and keep the pending bit.

// File: rtl/scsi_irq_pkg.sv
package scsi_irq_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;

  // read-side register indices
  localparam int unsigned IX_CMD    = 3;
  localparam int unsigned IX_STATUS = 4;
  localparam int unsigned IX_CAUSE  = 5;
  localparam int unsigned IX_STEP   = 6;
  localparam int unsigned IX_COUNT  = 7;
  localparam int unsigned IX_CFG    = 8;
  localparam int unsigned IX_MASKED = 11;
  localparam int unsigned IX_USER0  = 12;
  localparam int unsigned N_USER    = 4;

  // status bits
  localparam logic [7:0] ST_IRQ = 8'h80;
  localparam logic [7:0] ST_TC  = 8'h10;
  localparam logic [7:0] ST_DI  = 8'h01;
  // interrupt cause codes
  localparam logic [7:0] CA_FUNC = 8'h08;
  localparam logic [7:0] CA_SERV = 8'h10;
  localparam logic [7:0] CA_DISC = 8'h20;
  localparam logic [7:0] CA_BRST = 8'h80;
  localparam logic [7:0] STEP_CMD = 8'h04;
  localparam logic [7:0] MASK_11  = 8'h15;
  localparam int unsigned CFG_QUIET_BIT = 6;

  localparam logic [31:0] DMA_VERSION = 32'hA000_0000;
  localparam int unsigned DMA_EN_BIT  = 4;
  localparam int unsigned DMA_RST_BIT = 7;

  typedef enum logic [6:0] {
    CMD_FLUSH = 7'h01,
    CMD_CHIP  = 7'h02,
    CMD_BUS   = 7'h03,
    CMD_XFER  = 7'h10
  } cmd_e;

  function automatic logic [3:0] reg_index(input logic [5:0] addr);
    return addr[5:2];
  endfunction

  function automatic logic [7:0] status_after_ack(input logic [7:0] st);
    return st & ST_TC;
  endfunction

  function automatic logic [31:0] dma_word(input logic en, input logic pend);
    logic [31:0] w;
    w = DMA_VERSION;
    w[DMA_EN_BIT] = en;
    w[0] = pend;
    return w;
  endfunction
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_irq_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [7:0] cmd_byte,
  output logic       do_flush,
  output logic       do_chip_rst,
  output logic       do_bus_rst,
  output logic       do_ti
);
  logic [6:0] code;
  assign code = cmd_byte[6:0];

  always_comb begin
    do_flush    = 1'b0;
    do_chip_rst = 1'b0;
    do_bus_rst  = 1'b0;
    do_ti       = 1'b0;
    if (cmd_wr) begin
      case (code)
        CMD_FLUSH: do_flush    = 1'b1;
        CMD_CHIP:  do_chip_rst = 1'b1;
        CMD_BUS:   do_bus_rst  = 1'b1;
        CMD_XFER:  do_ti       = 1'b1;
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/scsi_irq_ctrl.sv
module scsi_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic raise,
  input  logic ack,
  input  logic en_wr,
  input  logic en_val,
  input  logic chip_rst,
  input  logic full_rst,
  output logic irq,
  output logic pend,
  output logic en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      pend <= 1'b0;
      en   <= 1'b0;
    end else begin
      if (chip_rst || full_rst) begin
        irq  <= 1'b0;
        pend <= 1'b0;
      end else if (raise) begin
        irq  <= 1'b1;
        pend <= 1'b1;
      end else begin
        if (ack || (en_wr && !en_val)) irq <= 1'b0;
        if (ack) pend <= 1'b0;
      end
      if (full_rst) en <= 1'b0;
      else if (en_wr) en <= en_val;
    end
  end
endmodule

// File: rtl/scsi_irq_regs.sv
module scsi_irq_regs
  import scsi_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dma_wr,
  input  logic [31:0]       dma_wdata,
  output logic [31:0]       dma_rdata,
  input  logic              ev_sel_ok,
  input  logic              ev_sel_fail,
  input  logic              ev_xfer_done,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              irq_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [7:0] status_q, intr_q, seq_q, count_q, r11_q, cfg_q;
  logic [7:0] st_n, in_n, sq_n, cn_n, r11_n, cfg_n;
  logic [7:0] user_q [N_USER];
  logic ack_rd, raise, rst_all, full_rst, cfg_quiet, dma_pend, dma_en;
  logic do_flush, do_chip_rst, do_bus_rst, do_ti;

  assign idx       = reg_index(bus_addr);
  assign ack_rd    = bus_rd && (idx == IX_CAUSE[IDX_W-1:0]);
  assign full_rst  = dma_wr && dma_wdata[DMA_RST_BIT];
  assign rst_all   = do_chip_rst || full_rst;
  assign cfg_quiet = cfg_q[CFG_QUIET_BIT];
  assign raise     = ev_sel_ok || ev_sel_fail || ev_xfer_done || do_ti ||
                     (do_bus_rst && !cfg_quiet);

  scsi_cmd_decode u_dec (
    .cmd_wr      (bus_wr && (idx == IX_CMD[IDX_W-1:0])),
    .cmd_byte    (bus_wdata),
    .do_flush    (do_flush),
    .do_chip_rst (do_chip_rst),
    .do_bus_rst  (do_bus_rst),
    .do_ti       (do_ti)
  );

  scsi_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .raise    (raise),
    .ack      (ack_rd),
    .en_wr    (dma_wr && !dma_wdata[DMA_RST_BIT]),
    .en_val   (dma_wdata[DMA_EN_BIT]),
    .chip_rst (do_chip_rst),
    .full_rst (full_rst),
    .irq      (irq_o),
    .pend     (dma_pend),
    .en       (dma_en)
  );

  // next state: ack first, then commands, then events (events win)
  always_comb begin
    st_n  = status_q;
    in_n  = intr_q;
    sq_n  = seq_q;
    cn_n  = count_q;
    r11_n = r11_q;
    cfg_n = cfg_q;
    if (ack_rd) st_n = status_after_ack(status_q);
    if (bus_wr && idx == IX_CFG[IDX_W-1:0]) cfg_n = bus_wdata;
    if (bus_wr && idx == IX_MASKED[IDX_W-1:0]) r11_n = bus_wdata & MASK_11;
    if (do_flush) begin
      in_n = CA_FUNC;
      sq_n = 8'h00;
    end
    if (do_bus_rst) in_n = CA_BRST;
    if (do_ti || ev_xfer_done) cn_n = 8'(xfer_len);
    if (ev_sel_fail) begin
      st_n = ST_IRQ;
      in_n = CA_DISC;
      sq_n = 8'h00;
    end else if (ev_sel_ok) begin
      st_n = ST_IRQ | ST_TC | ST_DI;
      in_n = CA_SERV | CA_FUNC;
      sq_n = STEP_CMD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || rst_all) begin
      status_q <= '0;
      intr_q   <= '0;
      seq_q    <= '0;
      count_q  <= '0;
      r11_q    <= '0;
      cfg_q    <= '0;
    end else begin
      status_q <= st_n;
      intr_q   <= in_n;
      seq_q    <= sq_n;
      count_q  <= cn_n;
      r11_q    <= r11_n;
      cfg_q    <= cfg_n;
    end
  end

  for (genvar g = 0; g < N_USER; g++) begin : g_user
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) user_q[g] <= '0;
      else if (rst_all) user_q[g] <= '0;
      else if (bus_wr && idx == IDX_W'(IX_USER0 + g)) user_q[g] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(idx))
      IX_STATUS: bus_rdata = status_q;
      IX_CAUSE:  bus_rdata = intr_q;
      IX_STEP:   bus_rdata = seq_q;
      IX_COUNT:  bus_rdata = count_q;
      IX_MASKED: bus_rdata = r11_q;
      default: begin
        for (int k = 0; k < N_USER; k++)
          if (int'(idx) == IX_USER0 + k) bus_rdata = user_q[k];
      end
    endcase
  end

  assign dma_rdata = dma_word(dma_en, dma_pend);
endmodule

// File: rtl/scsi_irq_regs_chk.sv
module scsi_irq_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_o,
  input logic       ack_rd,
  input logic       raise,
  input logic       rst_all,
  input logic       do_bus_rst,
  input logic       cfg_quiet,
  input logic       ev_sel_ok,
  input logic       ev_sel_fail,
  input logic [7:0] status_q,
  input logic [7:0] intr_q,
  input logic [7:0] seq_q
);
  assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && !raise && !rst_all) |=> (!irq_o && ((status_q & 8'hEF) == 8'h00)));

  assert_event_beats_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rd && raise && !rst_all) |=> irq_o);

  assert_quiet_bus_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (do_bus_rst && cfg_quiet && !raise && !irq_o && !rst_all) |=> !irq_o);

  assert_sel_ok_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel_ok && !ev_sel_fail && !rst_all) |=>
      (intr_q == 8'h18 && seq_q == 8'h04 && irq_o));

  assert_sel_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sel_fail && !rst_all) |=> (intr_q == 8'h20 && seq_q == 8'h00 && irq_o));

  assert_chip_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_all |=> (!irq_o && status_q == 8'h00 && intr_q == 8'h00));
endmodule

bind scsi_irq_regs scsi_irq_regs_chk chk_i (.*);

// File: tb/scsi_irq_regs_tb_top.sv
module scsi_irq_regs_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] bus_addr = '0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic dma_wr = 1'b0;
  logic [31:0] dma_wdata = '0;
  logic [31:0] dma_rdata;
  logic ev_sel_ok = 1'b0, ev_sel_fail = 1'b0, ev_xfer_done = 1'b0;
  logic [7:0] xfer_len = '0;
  logic irq_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;
  string cur_req = "R12";

  // reference model state
  int m_reg [16];
  int m_cfg, m_irq, m_pend, m_en;

  always #5 clk = ~clk;

  scsi_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
    .ev_sel_ok(ev_sel_ok), .ev_sel_fail(ev_sel_fail),
    .ev_xfer_done(ev_xfer_done), .xfer_len(xfer_len), .irq_o(irq_o)
  );

  task automatic model_clear();
    foreach (m_reg[i]) m_reg[i] = 0;
    m_cfg = 0; m_irq = 0; m_pend = 0;
  endtask

  function automatic int visible(int i);
    if (i == 4 || i == 5 || i == 6 || i == 7 || i >= 11) return m_reg[i];
    return 0;
  endfunction

  task automatic model_step();
    int i = bus_addr / 4;
    int code = bus_wdata % 128;
    bit cmd = bus_wr && i == 3;
    bit up = 0;
    if (cmd && code == 2) begin model_clear(); return; end
    if (dma_wr && dma_wdata[7]) begin model_clear(); m_en = 0; return; end
    if (bus_rd && i == 5) begin
      m_reg[4] = (m_reg[4] / 16 % 2) * 16; m_irq = 0; m_pend = 0;
    end
    if (bus_wr) begin
      if (i == 8) m_cfg = bus_wdata;
      if (i == 11) m_reg[11] = bus_wdata & 8'h15;
      if (i >= 12) m_reg[i] = bus_wdata;
    end
    if (dma_wr) begin
      m_en = dma_wdata[4];
      if (!dma_wdata[4]) m_irq = 0;
    end
    if (cmd && code == 1) begin m_reg[5] = 8; m_reg[6] = 0; end
    if (cmd && code == 3) begin
      m_reg[5] = 128;
      if ((m_cfg / 64) % 2 == 0) up = 1;
    end
    if ((cmd && code == 16) || ev_xfer_done) begin m_reg[7] = xfer_len; up = 1; end
    if (ev_sel_fail) begin
      m_reg[4] = 128; m_reg[5] = 32; m_reg[6] = 0; up = 1;
    end else if (ev_sel_ok) begin
      m_reg[4] = 145; m_reg[5] = 24; m_reg[6] = 4; up = 1;
    end
    if (up) begin m_irq = 1; m_pend = 1; end
  endtask

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
    end
  endtask

  // one clock: compare outputs, clock, update model, release inputs
  task automatic cyc();
    #1;
    chk("rdata", bus_rdata, visible(bus_addr / 4));
    chk("irq", irq_o, m_irq);
    chk("dma", dma_rdata, 32'hA000_0000 + m_en * 16 + m_pend);
    @(posedge clk);
    model_step();
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; dma_wr = 0;
    ev_sel_ok = 0; ev_sel_fail = 0; ev_xfer_done = 0;
  endtask

  task automatic rd(int i, int lo = 0);
    bus_addr = 6'(i * 4 + lo); bus_rd = 1; cyc();
  endtask
  task automatic wr(int i, int v);
    bus_addr = 6'(i * 4 + 2); bus_wr = 1; bus_wdata = 8'(v); cyc();
  endtask
  task automatic peek(int i);
    bus_addr = 6'(i * 4 + 1); cyc();
  endtask
  task automatic dw(int v);
    dma_wr = 1; dma_wdata = 32'(v); cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_clear(); m_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cur_req = "R12";
    for (int i = 0; i < 16; i++) peek(i);
    cur_req = "R8";
    wr(11, 8'hFF); peek(11);
    wr(12, 8'hA5); wr(13, 8'h3C); wr(14, 8'h01); wr(15, 8'hFE);
    for (int i = 12; i < 16; i++) peek(i);
    wr(9, 8'h77); wr(4, 8'h55); wr(7, 8'h66); peek(9); peek(4); peek(7);
    cur_req = "R1";
    for (int lo = 0; lo < 4; lo++) rd(13, lo);
    cur_req = "R6";
    ev_sel_ok = 1; cyc(); peek(4); peek(6);
    cur_req = "R2";
    rd(5); peek(4); peek(5);
    cur_req = "R5";
    ev_sel_fail = 1; ev_sel_ok = 1; cyc(); peek(4); peek(6);
    cur_req = "R2";
    rd(5, 3); peek(4);
    cur_req = "R3";
    ev_sel_ok = 1; cyc();
    wr(3, 8'h81); peek(5); peek(6);
    cur_req = "R4";
    rd(5); wr(3, 8'h03); peek(5); rd(5);
    wr(8, 8'h40); wr(3, 8'h03); peek(5); peek(4);
    wr(8, 8'hBF); wr(3, 8'h03); rd(5);
    cur_req = "R7";
    xfer_len = 8'h5A; ev_xfer_done = 1; cyc(); peek(7); rd(5);
    xfer_len = 8'h33; wr(3, 8'h10); peek(7); rd(5);
    cur_req = "R11";
    bus_addr = 6'd20; bus_rd = 1; ev_sel_ok = 1; cyc(); peek(5); peek(4);
    bus_addr = 6'd20; bus_rd = 1; xfer_len = 8'h0C; ev_xfer_done = 1; cyc(); peek(4);
    cur_req = "R9";
    rd(5); dw(32'h10); peek(5);
    ev_sel_fail = 1; cyc(); dw(32'h0); peek(5); dw(32'h10);
    ev_sel_ok = 1; cyc(); dw(32'h91); peek(4); peek(12);
    cur_req = "R10";
    wr(12, 8'h42); ev_sel_ok = 1; cyc(); dw(32'h10);
    wr(3, 8'h05); wr(3, 8'h7F); peek(5);
    wr(3, 8'h82); for (int i = 4; i < 16; i++) peek(i);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule